// File: doc/BRIEF.md
# Translation table bulk update engine

This block services commands that maintain the entry table of an I/O address translator. A single command can write one entry, read one entry back, fill a run of consecutive entries with one value, or load a run of entries from a list held in system memory. Every command names an I/O bus address. Fill and list commands also carry a page count, and the list command carries a pointer to the list. The engine drives an external table read/write port and a 64-bit memory-read port. For each entry it writes, it emits an invalidate notification so that cached translations can be dropped. It finishes every command with a done pulse and a status code.

The engine accepts one command at a time. `busy` rises when the command is taken and stays high until the cycle that carries `done` and `status`. Multi-page commands work through their pages one at a time. They stop at the first page whose index falls outside the table, and entries written before that page stay in place.

Top module: `xlt_bulk_engine`

## Requirements
- R1: A command's bus address is first aligned down to the page size (2^PAGE_SHIFT bytes). The entry index is (aligned address − BUS_OFFSET) >> PAGE_SHIFT, computed modulo 2^ADDR_W, so an address below the offset gives a huge index.
- R2: An index at or above NUM_ENTRIES gives status 1 (parameter error), and that entry is not written.
- R3: Opcode 0 (single write) stores `cmd_arg` at the entry for `cmd_ioba` and ignores `cmd_npages`.
- R4: Opcode 1 (single read) returns the stored entry on `rd_value` with status 0. An out-of-range index returns status 1.
- R5: Opcode 2 (fill) writes `cmd_arg` into `cmd_npages` consecutive entries, advancing the address by one page per step. The command is rejected with no table access when `cmd_npages` exceeds NUM_ENTRIES.
- R6: Opcode 3 (list load) is rejected with no access when `cmd_npages` exceeds MAX_LIST, or when any of the low 12 bits of the list pointer `cmd_arg` is set.
- R7: The list load reads word i from address (pointer with bits 1:0 cleared) + 8·i and writes it to the entry for page i of the run. It issues one read per page, and the read for a page comes before that page's index check.
- R8: A fill or list load stops at the first out-of-range page and returns status 1. Entries written earlier in that command keep their new values.
- R9: Every entry write emits one `ntf_valid` cycle. That cycle carries the page-aligned I/O address, the written value with its low PAGE_SHIFT bits cleared, an offset mask of 2^PAGE_SHIFT − 1, and the value's bits 1:0 as the permission.
- R10: Status 0 means success and status 1 means parameter error. `busy` is high from the accepting clock edge until the cycle in which `done` pulses for one cycle together with the status. A command is accepted only while `busy` is low.
- R11: A fill or list load with a page count of zero finishes at once with status 1, with no table or memory access.
- R12: A memory read is requested with `mem_req_valid`/`mem_req_ready`, and the address stays stable while the request waits. Only one read is outstanding at a time, and the read completes on `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present (taken when busy is low) |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list load |
| cmd_ioba | input | ADDR_W | I/O bus address |
| cmd_arg | input | DATA_W | Entry value or list pointer |
| cmd_npages | input | CNT_W | Page count for fill and list load |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | 0 success, 1 parameter error |
| rd_value | output | DATA_W | Entry returned by a read |
| tbl_we | output | 1 | Table write strobe |
| tbl_re | output | 1 | Table read strobe (data the next cycle) |
| tbl_idx | output | IDX_W | Table entry index |
| tbl_wdata | output | DATA_W | Table write data |
| tbl_rdata | input | DATA_W | Table read data |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W | Memory read data |
| ntf_valid | output | 1 | Invalidate notification |
| ntf_iova | output | ADDR_W | Page-aligned I/O address |
| ntf_xlat | output | DATA_W | Page-aligned translated address |
| ntf_mask | output | DATA_W | Offset mask within the page |
| ntf_perm | output | 2 | Permission bits |

## Verification
The bench uses the default parameters: twelve entries, 4 KiB pages, a bus offset of 0x10000 and a list limit of 512. With twelve entries, indexes 12 to 15 fit in the 4-bit index field yet lie beyond the table, so the range check is exercised apart from any truncation. Addresses below the offset reach the wrap-around case. Because the list limit is far larger than the table, a list load can run past the last entry partway through, which exercises early stop and the extra read it costs. A count of 513 reaches the limit rejection.

// File: rtl/xbe_pkg.sv
package xbe_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } xbe_op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WR    = 3'd1,
    S_RD    = 3'd2,
    S_RDW   = 3'd3,
    S_MREQ  = 3'd4,
    S_MWAIT = 3'd5,
    S_DONE  = 3'd6
  } xbe_state_e;

  localparam logic ST_OK    = 1'b0;
  localparam logic ST_PARAM = 1'b1;

endpackage

// File: rtl/xbe_index_calc.sv
module xbe_index_calc #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int NUM_ENTRIES = 12,
  parameter int IDX_W       = 4,
  parameter logic [ADDR_W-1:0] BUS_OFFSET = 'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] aligned,
  output logic [IDX_W-1:0]  idx,
  output logic              oob
);
  localparam logic [ADDR_W-1:0] OFS_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] page;

  always_comb begin
    aligned = addr & ~OFS_MASK;
    rel     = aligned - BUS_OFFSET;
    page    = rel >> PAGE_SHIFT;
    oob     = (page >= ADDR_W'(NUM_ENTRIES));
    idx     = page[IDX_W-1:0];
  end
endmodule

// File: rtl/xbe_notify_fmt.sv
module xbe_notify_fmt #(
  parameter int DATA_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] xlat,
  output logic [DATA_W-1:0] mask,
  output logic [1:0]        perm
);
  localparam logic [DATA_W-1:0] OFS_MASK = (DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1);

  always_comb begin
    mask = OFS_MASK;
    xlat = value & ~OFS_MASK;
    perm = value[1:0];
  end
endmodule

// File: rtl/xlt_bulk_engine.sv
module xlt_bulk_engine
  import xbe_pkg::*;
#(
  parameter int ADDR_W           = 32,
  parameter int DATA_W           = 64,
  parameter int PAGE_SHIFT       = 12,
  parameter int NUM_ENTRIES      = 12,
  parameter logic [ADDR_W-1:0] BUS_OFFSET = 'h0001_0000,
  parameter int MAX_LIST         = 512,
  parameter int LIST_ALIGN_SHIFT = 12,
  parameter int CNT_W            = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_ioba,
  input  logic [DATA_W-1:0] cmd_arg,
  input  logic [CNT_W-1:0]  cmd_npages,
  output logic              busy,
  output logic              done,
  output logic              status,
  output logic [DATA_W-1:0] rd_value,
  output logic              tbl_we,
  output logic              tbl_re,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [DATA_W-1:0] tbl_wdata,
  input  logic [DATA_W-1:0] tbl_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              ntf_valid,
  output logic [ADDR_W-1:0] ntf_iova,
  output logic [DATA_W-1:0] ntf_xlat,
  output logic [DATA_W-1:0] ntf_mask,
  output logic [1:0]        ntf_perm
);
  localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_SHIFT;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  xbe_state_e        state_q, state_n;
  xbe_op_e           op_q, op_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] arg_q, arg_n;
  logic [DATA_W-1:0] wval_q, wval_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic [CNT_W-1:0]  lidx_q, lidx_n;
  logic              status_q, status_n;
  logic [DATA_W-1:0] rdv_q;
  logic              rdv_en;

  logic [ADDR_W-1:0] ix_aligned;
  logic [IDX_W-1:0]  ix_idx;
  logic              ix_oob;
  logic [ADDR_W-1:0] list_base;
  logic              np_zero, ptr_misal;

  xbe_index_calc #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W(IDX_W), .BUS_OFFSET(BUS_OFFSET)
  ) u_idx (
    .addr(addr_q), .aligned(ix_aligned), .idx(ix_idx), .oob(ix_oob)
  );

  xbe_notify_fmt #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_ntf (
    .value(wval_q), .xlat(ntf_xlat), .mask(ntf_mask), .perm(ntf_perm)
  );

  assign np_zero   = (cmd_npages == '0);
  assign ptr_misal = |cmd_arg[LIST_ALIGN_SHIFT-1:0];
  assign list_base = {arg_q[ADDR_W-1:2], 2'b00};

  always_comb begin
    state_n  = state_q;
    op_n     = op_q;
    addr_n   = addr_q;
    arg_n    = arg_q;
    wval_n   = wval_q;
    rem_n    = rem_q;
    lidx_n   = lidx_q;
    status_n = status_q;
    rdv_en   = 1'b0;
    tbl_we   = 1'b0;
    tbl_re   = 1'b0;
    mem_req_valid = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          op_n     = xbe_op_e'(cmd_op);
          addr_n   = cmd_ioba;
          arg_n    = cmd_arg;
          wval_n   = cmd_arg;
          rem_n    = cmd_npages;
          lidx_n   = '0;
          status_n = ST_OK;
          unique case (xbe_op_e'(cmd_op))
            OP_PUT: begin
              rem_n   = CNT_W'(1);
              state_n = S_WR;
            end
            OP_GET: state_n = S_RD;
            OP_FILL: begin
              if (np_zero || cmd_npages > CNT_W'(NUM_ENTRIES)) begin
                status_n = ST_PARAM;
                state_n  = S_DONE;
              end else begin
                state_n = S_WR;
              end
            end
            OP_LIST: begin
              if (np_zero || cmd_npages > CNT_W'(MAX_LIST) || ptr_misal) begin
                status_n = ST_PARAM;
                state_n  = S_DONE;
              end else begin
                state_n = S_MREQ;
              end
            end
            default: state_n = S_IDLE;
          endcase
        end
      end
      S_WR: begin
        if (ix_oob) begin
          status_n = ST_PARAM;
          state_n  = S_DONE;
        end else begin
          tbl_we = 1'b1;
          if (rem_q == CNT_W'(1)) begin
            state_n = S_DONE;
          end else begin
            rem_n   = rem_q - CNT_W'(1);
            addr_n  = addr_q + PAGE_BYTES;
            state_n = (op_q == OP_LIST) ? S_MREQ : S_WR;
          end
        end
      end
      S_MREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) begin
          lidx_n  = lidx_q + CNT_W'(1);
          state_n = S_MWAIT;
        end
      end
      S_MWAIT: begin
        if (mem_rsp_valid) begin
          wval_n  = mem_rsp_data;
          state_n = S_WR;
        end
      end
      S_RD: begin
        if (ix_oob) begin
          status_n = ST_PARAM;
          state_n  = S_DONE;
        end else begin
          tbl_re  = 1'b1;
          state_n = S_RDW;
        end
      end
      S_RDW: begin
        rdv_en  = 1'b1;
        state_n = S_DONE;
      end
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= S_IDLE;
      op_q     <= OP_PUT;
      addr_q   <= '0;
      arg_q    <= '0;
      wval_q   <= '0;
      rem_q    <= '0;
      lidx_q   <= '0;
      status_q <= ST_OK;
      rdv_q    <= '0;
    end else begin
      state_q  <= state_n;
      op_q     <= op_n;
      addr_q   <= addr_n;
      arg_q    <= arg_n;
      wval_q   <= wval_n;
      rem_q    <= rem_n;
      lidx_q   <= lidx_n;
      status_q <= status_n;
      if (rdv_en) rdv_q <= tbl_rdata;
    end
  end

  assign busy         = (state_q != S_IDLE);
  assign done         = (state_q == S_DONE);
  assign status       = status_q;
  assign rd_value     = rdv_q;
  assign tbl_idx      = ix_idx;
  assign tbl_wdata    = wval_q;
  assign mem_req_addr = list_base + (ADDR_W'(lidx_q) << 3);
  assign ntf_valid    = tbl_we;
  assign ntf_iova     = ix_aligned;
endmodule

// File: rtl/xlt_bulk_engine_chk.sv
module xlt_bulk_engine_chk #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int NUM_ENTRIES = 12,
  parameter int IDX_W       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              tbl_we,
  input logic              tbl_re,
  input logic [IDX_W-1:0]  tbl_idx,
  input logic [DATA_W-1:0] tbl_wdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              ntf_valid,
  input logic [ADDR_W-1:0] ntf_iova,
  input logic [DATA_W-1:0] ntf_xlat,
  input logic [DATA_W-1:0] ntf_mask,
  input logic [1:0]        ntf_perm
);
  localparam int IDX_P1 = IDX_W + 1;

  logic pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
    else if (mem_rsp_valid) pend_q <= 1'b0;
  end

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r10_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tbl_we && !tbl_re && !mem_req_valid));
  a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> ({1'b0, tbl_idx} < IDX_P1'(NUM_ENTRIES)));
  a_r12_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !pend_q);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r7_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
  a_r9_ntf_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ((ntf_xlat & ntf_mask) == '0 && ntf_perm == tbl_wdata[1:0]
                   && ntf_iova[PAGE_SHIFT-1:0] == '0));
endmodule

bind xlt_bulk_engine xlt_bulk_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT),
  .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tbl_we(tbl_we),
  .tbl_re(tbl_re), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlat(ntf_xlat),
  .ntf_mask(ntf_mask), .ntf_perm(ntf_perm)
);

// File: tb/xlt_bulk_engine_tb.sv
module xlt_bulk_engine_tb;
  localparam int NE = 12;
  localparam logic [31:0] OFF = 32'h0001_0000;
  localparam logic [31:0] PG  = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_ioba = '0;
  logic [63:0] cmd_arg = '0;
  logic [15:0] cmd_npages = '0;
  logic        busy, done, status;
  logic [63:0] rd_value;
  logic        tbl_we, tbl_re;
  logic [3:0]  tbl_idx;
  logic [63:0] tbl_wdata;
  logic [63:0] tbl_rdata = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        ntf_valid;
  logic [31:0] ntf_iova;
  logic [63:0] ntf_xlat, ntf_mask;
  logic [1:0]  ntf_perm;

  xlt_bulk_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ioba(cmd_ioba), .cmd_arg(cmd_arg), .cmd_npages(cmd_npages),
    .busy(busy), .done(done), .status(status), .rd_value(rd_value),
    .tbl_we(tbl_we), .tbl_re(tbl_re), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
    .tbl_rdata(tbl_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlat(ntf_xlat),
    .ntf_mask(ntf_mask), .ntf_perm(ntf_perm)
  );

  int nchecks = 0;
  int nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // table and memory models
  logic [63:0] tbl_m [NE];
  logic [63:0] exp_tbl [NE];
  int hs_cnt = 0;
  int hs_seen = 0;
  logic [31:0] hs_addr = '0;
  bit pend = 0;
  int dly = 0;
  logic [31:0] paddr = '0;

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a ^ 32'hC0DE_0000, a * 32'd5 + 32'd1};
  endfunction

  always @(posedge clk) begin
    if (tbl_we) tbl_m[tbl_idx] <= tbl_wdata;
    if (tbl_re) tbl_rdata <= tbl_m[tbl_idx];
    if (mem_req_valid && mem_req_ready) begin
      hs_cnt  <= hs_cnt + 1;
      hs_addr <= mem_req_addr;
    end
  end

  always @(negedge clk) begin
    mem_req_ready = ($urandom % 3) != 0;
    mem_rsp_valid = 1'b0;
    if (hs_cnt != hs_seen) begin
      hs_seen = hs_cnt;
      pend = 1;
      paddr = hs_addr;
      dly = $urandom % 3;
    end
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(paddr);
        pend = 0;
      end else begin
        dly--;
      end
    end
  end

  // expected model
  int exp_status, exp_nw, exp_mreq;
  logic [63:0] exp_rd;
  logic [31:0] exp_ntf_iova [16];
  logic [63:0] exp_ntf_val [16];
  int ntf_seen = 0;
  int ntf_base = 0;

  function automatic logic [31:0] page_of(input logic [31:0] a);
    return ((a & ~(PG - 32'd1)) - OFF) >> 12;
  endfunction

  task automatic exp_write(input logic [31:0] a, input logic [63:0] v);
    exp_tbl[page_of(a)] = v;
    exp_ntf_iova[exp_nw] = a & ~(PG - 32'd1);
    exp_ntf_val[exp_nw] = v;
    exp_nw++;
  endtask

  task automatic model(input int op, input logic [31:0] ioba, input logic [63:0] arg, input int np);
    logic [31:0] a;
    exp_status = 0; exp_nw = 0; exp_mreq = 0;
    a = ioba & ~(PG - 32'd1);
    case (op)
      0: if (page_of(a) < NE) exp_write(a, arg); else exp_status = 1;
      1: if (page_of(a) < NE) exp_rd = exp_tbl[page_of(a)]; else exp_status = 1;
      2: begin
        if (np == 0 || np > NE) exp_status = 1;
        else for (int i = 0; i < np; i++) begin
          if (page_of(a + PG * i) >= NE) begin exp_status = 1; break; end
          exp_write(a + PG * i, arg);
        end
      end
      default: begin
        if (np == 0 || np > 512 || arg[11:0] != 12'h0) exp_status = 1;
        else for (int i = 0; i < np; i++) begin
          exp_mreq++;
          if (page_of(a + PG * i) >= NE) begin exp_status = 1; break; end
          exp_write(a + PG * i, mem_word({arg[31:2], 2'b00} + 32'd8 * i));
        end
      end
    endcase
  endtask

  // notification monitor (R9)
  always @(negedge clk) begin
    if (rst_n && ntf_valid) begin
      int k;
      k = ntf_seen - ntf_base;
      if (k < exp_nw) begin
        chk(ntf_iova == exp_ntf_iova[k], "R9 iova", 64'(ntf_iova), 64'(exp_ntf_iova[k]));
        chk(ntf_xlat == (exp_ntf_val[k] & ~64'hFFF) && ntf_mask == 64'hFFF &&
            ntf_perm == exp_ntf_val[k][1:0], "R9 fields", ntf_xlat, exp_ntf_val[k]);
      end else begin
        chk(1'b0, "R9 extra notification", 64'(k), 64'(exp_nw));
      end
      ntf_seen++;
    end
  end

  task automatic run_cmd(input int op, input logic [31:0] ioba, input logic [63:0] arg,
                         input int np, input string tag);
    int hs0, t;
    bit same;
    model(op, ioba, arg, np);
    ntf_base = ntf_seen;
    hs0 = hs_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_ioba = ioba; cmd_arg = arg; cmd_npages = 16'(np);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, {tag, " R10 busy after accept"}, 64'(busy), 64'd1);
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1'b1, {tag, " R10 done seen"}, 64'(done), 64'd1);
    chk(status == 1'(exp_status), {tag, " R2/R8/R10 status"}, 64'(status), 64'(exp_status));
    if (op == 1 && exp_status == 0)
      chk(rd_value == exp_rd, {tag, " R4 read value"}, rd_value, exp_rd);
    chk(ntf_seen - ntf_base == exp_nw, {tag, " R9 write count"}, 64'(ntf_seen - ntf_base), 64'(exp_nw));
    chk(hs_cnt - hs0 == exp_mreq, {tag, " R7/R12 read count"}, 64'(hs_cnt - hs0), 64'(exp_mreq));
    same = 1;
    for (int i = 0; i < NE; i++) if (tbl_m[i] !== exp_tbl[i]) same = 0;
    chk(same, {tag, " R3/R5/R8 table contents"}, 64'(same), 64'd1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, {tag, " R10 idle after done"}, 64'({busy, done}), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NE; i++) begin tbl_m[i] = '0; exp_tbl[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && tbl_we == 0 && mem_req_valid == 0,
        "R10 reset state", 64'({busy, done, tbl_we, mem_req_valid}), 64'd0);

    run_cmd(0, OFF + 32'h0abc, 64'h1234_5678_9abc_d003, 0, "R1 R3 put idx0 unaligned");
    run_cmd(1, OFF + 32'h0fff, 64'd0, 0, "R1 R4 get idx0");
    run_cmd(0, OFF + PG * 11, 64'hdead_beef_0000_1002, 7, "R3 put last idx");
    run_cmd(0, OFF + PG * 12, 64'h55, 0, "R2 put idx12");
    run_cmd(1, OFF + PG * 15, 64'd0, 0, "R4 get idx15");
    run_cmd(0, OFF - PG, 64'h77, 0, "R1 below offset");
    run_cmd(2, OFF, 64'h99, 0, "R11 fill zero");
    run_cmd(2, OFF, 64'h99, 13, "R5 fill too many");
    run_cmd(2, OFF, 64'hface_0001, 12, "R5 fill whole table");
    run_cmd(2, OFF + PG * 10, 64'hcafe_0002, 5, "R8 fill past end");
    run_cmd(3, OFF, 64'h0004_0000, 0, "R11 list zero");
    run_cmd(3, OFF, 64'h0004_0000, 513, "R6 list too many");
    run_cmd(3, OFF, 64'h0004_0800, 2, "R6 list misaligned");
    run_cmd(3, OFF + PG * 2, 64'h0005_0000, 3, "R7 list three");
    run_cmd(3, OFF, 64'h0006_0000, 512, "R8 list max past end");
    run_cmd(1, OFF + PG * 4, 64'd0, 0, "R4 get after list");

    for (int n = 0; n < 150; n++) begin
      int op, np;
      logic [31:0] io;
      logic [63:0] arg;
      op = $urandom % 4;
      io = OFF + PG * ($urandom % 16) + ($urandom % 4096);
      if ($urandom % 10 == 0) io = OFF - PG * (1 + $urandom % 4);
      np = $urandom % 15;
      if ($urandom % 20 == 0) np = 513;
      if (op == 3) begin
        arg = {32'd0, 8'($urandom % 256), 12'd0, 12'd0};
        if ($urandom % 8 == 0) arg = arg | 64'(1 + $urandom % 4095);
      end else begin
        arg = {$urandom, $urandom};
      end
      run_cmd(op, io, arg, np, "rand");
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchecks++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end
endmodule